// File: doc/BRIEF.md
# Atomic Swap Memory Arbiter

This block places a small word-addressed memory behind several requester ports and lets each port run a load, a store or an indivisible swap on any word. A swap writes the port's data into the addressed word and returns the value the word held before, with no access from any other port between the read and the write. Every access returns the old contents of the addressed word one cycle after the port is granted.

The main use is a spin lock kept in one word, where 0 means free and 1 means held. A requester swaps in 1 and retries while the returned value is non-zero. When it gets back 0, it owns the lock. It releases the lock with an ordinary store of 0. Shared counters that sit under such a lock cannot lose updates, although a separate read, add and write sequence from two ports can.

A round-robin arbiter grants at most one port per cycle. Each access completes in the cycle it is granted, so no other port can touch the word in between.

Top module: `swap_lock_arbiter`

## Requirements
- R1: In any cycle at most one bit of `req_ready` is high, and a bit is high only while the same port's `req_valid` is high.
- R2: Whenever at least one port has `req_valid` high, exactly one port is granted in that cycle, even if the pointer favours a port that is idle.
- R3: Grants rotate. After reset, port 0 has first priority. After a grant to port g, priority starts at the next port in cyclic order (g+1 modulo the port count). With both ports requesting all the time, the grants alternate 0, 1, 0, 1.
- R4: `rsp_valid` for a port is high for exactly the one cycle after that port's grant and low otherwise. `rsp_rdata` then carries the word's contents from before the access.
- R5: Op code 0 (load) returns the addressed word and leaves it unchanged.
- R6: Op code 1 (store) writes `req_wdata` into the addressed word and returns the previous contents.
- R7: Op code 2 (swap) returns the previous contents and writes `req_wdata` in the same granted cycle. The next access from any port sees the new value.
- R8: Op code 3 is reserved and acts as a load. Its write data has no effect on memory.
- R9: Reset clears every memory word to 0 and holds `rsp_valid` and `rsp_rdata` at 0.
- R10: Two ports that repeatedly take the lock word by swap, read and add to a counter word, store it back, and release with a store of 0 end with a counter equal to the initial value plus every addend. For example, 5 plus 10 and 33 gives 48, not 15 or 38. At no time do both ports hold the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Request valid, one bit per port |
| req_ready | output | NPORTS | Grant, one-hot, one bit per port |
| req_op | input | 2*NPORTS | Op code per port: 0 load, 1 store, 2 swap, 3 reserved |
| req_addr | input | AW*NPORTS | Word address per port |
| req_wdata | input | DW*NPORTS | Write data per port |
| rsp_valid | output | NPORTS | Response pulse, one cycle after grant |
| rsp_rdata | output | DW | Previous word contents for the responding port |

## Verification
Every address is swept with all four op codes in turn, and the accesses alternate between ports. Each return value then shows whether the previous access wrote, skipped the write or changed the wrong word. Holding both ports' requests high separates round-robin rotation from fixed priority. A single requester shows that a grant is not withheld when the pointer favours an idle port. In the lock phase, two ports contend on a shared counter with unequal addends. A swap that is not indivisible, or a grant given in the middle of an access, shows up as a lost addend in the final total or as both ports holding the lock at once.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_SWAP  = 2'd2,
        OP_RSVD  = 2'd3
    } swp_op_e;

    // store and swap update memory; load and the reserved code do not
    function automatic logic op_writes(swp_op_e op);
        return (op == OP_STORE) || (op == OP_SWAP);
    endfunction

endpackage

// File: rtl/swp_rr_arb.sv
module swp_rr_arb #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IW-1:0] ptr;   // port with first priority this cycle
    } arb_state_t;

    arb_state_t s_d, s_q;

    always_comb begin
        logic found;
        int   idx;
        s_d   = s_q;
        gnt   = '0;
        found = 1'b0;
        idx   = 0;
        for (int off = 0; off < N; off++) begin
            idx = (int'(s_q.ptr) + off) % N;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                s_d.ptr  = IW'((idx + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/swp_word_mem.sv
module swp_word_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] old_word
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] words;
    } mem_state_t;

    mem_state_t s_d, s_q;

    // read of the old word and write of the new one share one edge
    always_comb begin
        s_d      = s_q;
        old_word = s_q.words[addr];
        if (acc_en && wr_en) s_d.words[addr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/swap_lock_arbiter.sv
module swap_lock_arbiter
    import swp_pkg::*;
#(
    parameter  int NPORTS = 2,
    parameter  int DW     = 32,
    parameter  int DEPTH  = 16,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORTS-1:0]    req_valid,
    output logic [NPORTS-1:0]    req_ready,
    input  logic [2*NPORTS-1:0]  req_op,
    input  logic [AW*NPORTS-1:0] req_addr,
    input  logic [DW*NPORTS-1:0] req_wdata,
    output logic [NPORTS-1:0]    rsp_valid,
    output logic [DW-1:0]        rsp_rdata
);
    typedef struct packed {
        logic [NPORTS-1:0] vld;
        logic [DW-1:0]     data;
    } rsp_state_t;

    rsp_state_t     s_d, s_q;
    logic [NPORTS-1:0] gnt;
    swp_op_e        sel_op;
    logic [AW-1:0]  sel_addr;
    logic [DW-1:0]  sel_wdata;
    logic           any_gnt;
    logic [DW-1:0]  old_word;

    swp_rr_arb #(.N(NPORTS)) i_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req_valid),
        .gnt  (gnt)
    );

    always_comb begin
        sel_op    = OP_LOAD;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (gnt[i]) begin
                sel_op    = swp_op_e'(req_op[i*2 +: 2]);
                sel_addr  = req_addr[i*AW +: AW];
                sel_wdata = req_wdata[i*DW +: DW];
            end
        end
    end

    assign any_gnt = |gnt;

    swp_word_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (any_gnt),
        .wr_en   (op_writes(sel_op)),
        .addr    (sel_addr),
        .wdata   (sel_wdata),
        .old_word(old_word)
    );

    always_comb begin
        s_d      = s_q;
        s_d.vld  = gnt;
        if (any_gnt) s_d.data = old_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready = gnt;
    assign rsp_valid = s_q.vld;
    assign rsp_rdata = s_q.data;

endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
    parameter int NPORTS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORTS-1:0] req_valid,
    input logic [NPORTS-1:0] req_ready,
    input logic [NPORTS-1:0] rsp_valid
);
    logic [NPORTS-1:0] fire;
    assign fire = req_valid & req_ready;

    a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    a_r1_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    a_r2_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |-> (|req_ready));

    a_r4_rsp_tracks_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> (rsp_valid == $past(fire)));

    a_r4_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(|fire) |=> (rsp_valid == '0));

endmodule

bind swap_lock_arbiter swp_checker #(.NPORTS(NPORTS)) i_swp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid)
);

// File: tb/test_swap_lock_arbiter.sv
module test_swap_lock_arbiter;
    localparam int NP = 2;
    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int AW = 4;
    localparam int ITER = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          tb_valid [NP];
    logic [1:0]    tb_op    [NP];
    logic [AW-1:0] tb_addr  [NP];
    logic [DW-1:0] tb_wd    [NP];

    logic [NP-1:0]    req_valid, req_ready, rsp_valid;
    logic [2*NP-1:0]  req_op;
    logic [AW*NP-1:0] req_addr;
    logic [DW*NP-1:0] req_wdata;
    logic [DW-1:0]    rsp_rdata;

    assign req_valid = {tb_valid[1], tb_valid[0]};
    assign req_op    = {tb_op[1], tb_op[0]};
    assign req_addr  = {tb_addr[1], tb_addr[0]};
    assign req_wdata = {tb_wd[1], tb_wd[0]};

    swap_lock_arbiter #(.NPORTS(NP), .DW(DW), .DEPTH(DEPTH)) i_swap_lock_arbiter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int holders = 0;
    int expected_total;

    task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // one access from port p; returns the response data
    task automatic xfer(int p, logic [1:0] op, logic [AW-1:0] a,
                        logic [DW-1:0] wd, output logic [DW-1:0] rd);
        @(negedge clk);
        tb_valid[p] = 1'b1; tb_op[p] = op; tb_addr[p] = a; tb_wd[p] = wd;
        #5;
        while (!req_ready[p]) begin
            @(negedge clk);
            #5;
        end
        chk($countones(req_ready) == 1, "R1", DW'(req_ready), 32'h1);
        @(negedge clk);
        tb_valid[p] = 1'b0;
        chk(rsp_valid[p] == 1'b1, "R4", DW'(rsp_valid), DW'(1 << p));
        rd = rsp_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < NP; i++) begin
            tb_valid[i] = 1'b0; tb_op[i] = '0; tb_addr[i] = '0; tb_wd[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(rsp_valid == '0, "R9", DW'(rsp_valid), 0);
        chk(rsp_rdata == '0, "R9", rsp_rdata, 0);
        rst_n = 1'b1;
    endtask

    // lock, add, unlock loop for one port (R10)
    task automatic worker(int p);
        logic [DW-1:0] rd, cnt, add;
        for (int k = 0; k < ITER; k++) begin
            add = (k == 0) ? ((p == 0) ? 32'd10 : 32'd33) : 32'd1;
            rd = 32'd1;
            while (rd != 0) xfer(p, 2'd2, 4'd1, 32'd1, rd);
            holders++;
            chk(holders == 1, "R10", DW'(holders), 1);
            xfer(p, 2'd0, 4'd2, 32'd0, cnt);
            xfer(p, 2'd1, 4'd2, cnt + add, rd);
            holders--;
            xfer(p, 2'd1, 4'd1, 32'd0, rd);
            chk(rd == 32'd1, "R10", rd, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R10: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] rd, f, g;
        logic [NP-1:0] gexp;

        // reset state and cleared memory
        do_reset();
        @(negedge clk);
        chk(req_ready == '0 && rsp_valid == '0, "R9", DW'(req_ready), 0);
        for (int a = 0; a < DEPTH; a++) begin
            xfer(a % 2, 2'd0, AW'(a), 32'hFFFF_FFFF, rd);
            chk(rd == 0, "R9", rd, 0);
        end

        // op sweep over every word, ports alternating
        for (int a = 0; a < DEPTH; a++) begin
            f = 32'hA5C3_0000 ^ (32'(a) * 32'h0101_0101);
            g = ~f;
            xfer(0, 2'd1, AW'(a), f, rd);
            chk(rd == 0, "R6", rd, 0);
            xfer(1, 2'd0, AW'(a), 32'hDEAD_BEEF, rd);
            chk(rd == f, "R5", rd, f);
            xfer(1, 2'd2, AW'(a), g, rd);
            chk(rd == f, "R7", rd, f);
            xfer(0, 2'd3, AW'(a), 32'h1234_5678, rd);
            chk(rd == g, "R7", rd, g);
            xfer(0, 2'd0, AW'(a), 32'h0, rd);
            chk(rd == g, "R8", rd, g);
        end
        // neighbour words untouched by the sweep writes
        xfer(1, 2'd0, 4'd0, 32'h0, rd);
        chk(rd == ~32'hA5C3_0000, "R6", rd, ~32'hA5C3_0000);

        // rotation from reset with both ports requesting
        do_reset();
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            tb_valid[i] = 1'b1; tb_op[i] = 2'd0; tb_addr[i] = 4'd3;
        end
        for (int k = 0; k < 6; k++) begin
            #5;
            gexp = (k % 2 == 0) ? 2'b01 : 2'b10;
            chk(req_ready == gexp, "R3", DW'(req_ready), DW'(gexp));
            @(negedge clk);
            chk(rsp_valid == gexp, "R4", DW'(rsp_valid), DW'(gexp));
        end
        // only port 1 while the pointer favours port 0
        tb_valid[0] = 1'b0;
        #5;
        chk(req_ready == 2'b10, "R2", DW'(req_ready), 2);
        @(negedge clk);
        tb_valid[1] = 1'b0;
        #5;
        chk(req_ready == 2'b00, "R1", DW'(req_ready), 0);
        chk(rsp_valid == 2'b10, "R4", DW'(rsp_valid), 2);
        @(negedge clk);
        chk(rsp_valid == 2'b00, "R4", DW'(rsp_valid), 0);

        // contended lock around a shared counter
        xfer(0, 2'd1, 4'd2, 32'd5, rd);
        expected_total = 5 + 10 + 33 + 2 * (ITER - 1);
        fork
            worker(0);
            worker(1);
        join
        xfer(0, 2'd0, 4'd2, 32'd0, rd);
        chk(rd == 32'(expected_total), "R10", rd, 32'(expected_total));
        xfer(1, 2'd0, 4'd1, 32'd0, rd);
        chk(rd == 0, "R10", rd, 0);

        summary();
        $finish;
    end

endmodule